// File: doc/BRIEF.md
# Two-Level Priority Round-Robin Channel Arbiter

This arbiter picks which of N transfer channels is served next. Each channel has a request flag, an enable flag and a priority code. A channel counts as pending only while both its request and its enable are high. The arbiter first finds the most urgent priority class that has at least one pending channel. It then uses round-robin to choose among the pending channels of that class.

The decision is combinational in every cycle. The consumer takes the offered channel by raising the accept strobe while the grant is valid. Each priority class keeps its own rotation pointer, and a pointer moves only when that class's grant is accepted. When nothing is pending, the grant flag drops and the channel index keeps showing the last channel that was offered.

Top module: `prio_rr_arbiter`

## Requirements
- R1: `grant_valid_o` is 1 exactly when at least one channel has both `req_i[c]` and `en_i[c]` at 1.
- R2: A channel whose `en_i` bit is 0 is never granted, even while its `req_i` bit is 1.
- R3: The priority code of channel c is `prio_i[2c+1:2c]`, where 0 is the most urgent and 3 the least. The granted channel always has the numerically smallest code among the pending channels.
- R4: Within a class, the search starts at the channel just after that class's last accepted channel and wraps from N-1 to 0. After reset, every class starts its search at channel 0, so the lowest pending index wins first.
- R5: A class pointer advances only in a cycle where `accept_i` and `grant_valid_o` are both 1. Without acceptance the same channel is offered again, and an accept while no grant is valid changes nothing.
- R6: Each class has its own pointer. Accepting a grant in one class leaves the rotation order of every other class unchanged.
- R7: While no channel is pending, `grant_valid_o` is 0 and `grant_idx_o` holds the last index shown with a valid grant. The index is 0 after reset.
- R8: Every decision uses the priority codes present in that same cycle, so a change of a channel's code takes effect in the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CH | Per-channel request |
| en_i | input | N_CH | Per-channel enable; 0 masks the request |
| prio_i | input | N_CH*PRIO_W | Packed priority codes, channel c at bits [PRIO_W*c +: PRIO_W] |
| accept_i | input | 1 | Consumer takes the offered grant this cycle |
| grant_valid_o | output | 1 | A channel is offered |
| grant_idx_o | output | $clog2(N_CH) | Offered channel, or the last offered one while idle |

## Verification
The assertions assume that `req_i`, `en_i`, `prio_i` and `accept_i` are settled well before each rising edge. They also assume that `accept_i` counts only while `grant_valid_o` is high. The stall property further assumes that a stable offer will be stable only if those inputs did not change across the edge. The bench changes inputs only on falling edges and samples one nanosecond later. It raises accept both with and without a valid grant, so the accept-while-idle case falls within what the checker allows.

// File: rtl/prio_rr_pkg.sv
package prio_rr_pkg;

  // Channel that follows idx in a ring of n channels.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Channel that sits off steps after base in a ring of n channels.
  function automatic int unsigned ring_step(input int unsigned base, input int unsigned off,
                                            input int unsigned n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/prio_rr_grp_mask.sv
module prio_rr_grp_mask #(
  parameter int N_CH    = 8,
  parameter int PRIO_W  = 2,
  parameter int NUM_GRP = 1 << PRIO_W
) (
  input  logic [N_CH-1:0]                 req_i,
  input  logic [N_CH-1:0]                 en_i,
  input  logic [N_CH*PRIO_W-1:0]          prio_i,
  output logic [NUM_GRP-1:0][N_CH-1:0]    grp_mask_o
);

  logic [N_CH-1:0] pending;
  assign pending = req_i & en_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign grp_mask_o[g][c] = pending[c] &&
                                (prio_i[c*PRIO_W +: PRIO_W] == PRIO_W'(g));
    end
  end

endmodule

// File: rtl/prio_rr_group.sv
module prio_rr_group #(
  parameter int N_CH  = 8,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  mask_i,
  input  logic             adv_i,
  output logic             pick_vld_o,
  output logic [IDX_W-1:0] pick_idx_o
);
  import prio_rr_pkg::*;

  logic [IDX_W-1:0] ptr_q;

  // Scans the ring starting one past the pointer; the pointer itself is tried last.
  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = ptr_q;
    for (int off = 1; off <= N_CH; off++) begin
      int unsigned cand;
      cand = ring_step(int'(ptr_q), off, N_CH);
      if (!pick_vld_o && mask_i[cand]) begin
        pick_vld_o = 1'b1;
        pick_idx_o = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= IDX_W'(N_CH - 1);
    else if (adv_i && pick_vld_o)
      ptr_q <= pick_idx_o;
  end

endmodule

// File: rtl/prio_rr_grp_sel.sv
module prio_rr_grp_sel #(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = $clog2(NUM_GRP)
) (
  input  logic [NUM_GRP-1:0] grp_vld_i,
  output logic               any_o,
  output logic [GRP_W-1:0]   sel_o
);

  // Lowest class number is the most urgent.
  always_comb begin
    sel_o = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (grp_vld_i[g]) sel_o = GRP_W'(g);
    end
  end

  assign any_o = |grp_vld_i;

endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          req_i,
  input  logic [N_CH-1:0]          en_i,
  input  logic [N_CH*PRIO_W-1:0]   prio_i,
  input  logic                     accept_i,
  output logic                     grant_valid_o,
  output logic [$clog2(N_CH)-1:0]  grant_idx_o
);
  localparam int NUM_GRP = 1 << PRIO_W;
  localparam int GRP_W   = PRIO_W;
  localparam int IDX_W   = $clog2(N_CH);

  logic [NUM_GRP-1:0][N_CH-1:0]  grp_mask;
  logic [NUM_GRP-1:0]            grp_vld;
  logic [NUM_GRP-1:0][IDX_W-1:0] grp_idx;
  logic [NUM_GRP-1:0]            grp_adv;
  logic                          any_pend;
  logic [GRP_W-1:0]              win_grp;
  logic [IDX_W-1:0]              win_idx;
  logic                          take_evt;
  logic [IDX_W-1:0]              last_q;

  prio_rr_grp_mask #(.N_CH(N_CH), .PRIO_W(PRIO_W), .NUM_GRP(NUM_GRP)) u_mask (
    .req_i      (req_i),
    .en_i       (en_i),
    .prio_i     (prio_i),
    .grp_mask_o (grp_mask)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_rr
    assign grp_adv[g] = take_evt && (win_grp == GRP_W'(g));
    prio_rr_group #(.N_CH(N_CH), .IDX_W(IDX_W)) u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_i     (grp_mask[g]),
      .adv_i      (grp_adv[g]),
      .pick_vld_o (grp_vld[g]),
      .pick_idx_o (grp_idx[g])
    );
  end

  prio_rr_grp_sel #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_sel (
    .grp_vld_i (grp_vld),
    .any_o     (any_pend),
    .sel_o     (win_grp)
  );

  assign win_idx  = grp_idx[win_grp];
  assign take_evt = accept_i && any_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)        last_q <= '0;
    else if (any_pend) last_q <= win_idx;
  end

  assign grant_valid_o = any_pend;
  assign grant_idx_o   = any_pend ? win_idx : last_q;

endmodule

// File: rtl/prio_rr_arbiter_chk.sv
module prio_rr_arbiter_chk #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_CH-1:0]          req_i,
  input logic [N_CH-1:0]          en_i,
  input logic [N_CH*PRIO_W-1:0]   prio_i,
  input logic                     accept_i,
  input logic                     grant_valid_o,
  input logic [$clog2(N_CH)-1:0]  grant_idx_o
);
  logic armed_q;
  logic most_urgent;

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_comb begin
    most_urgent = 1'b1;
    for (int c = 0; c < N_CH; c++) begin
      if (req_i[c] && en_i[c] &&
          prio_i[c*PRIO_W +: PRIO_W] < prio_i[int'(grant_idx_o)*PRIO_W +: PRIO_W])
        most_urgent = 1'b0;
    end
  end

  assert_valid_iff_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o == (|(req_i & en_i)));

  assert_grant_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (en_i[grant_idx_o] && req_i[grant_idx_o]));

  assert_most_urgent_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> most_urgent);

  assert_idle_holds_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !grant_valid_o && !$past(grant_valid_o)) |-> $stable(grant_idx_o));

  assert_stall_repeats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(accept_i) && $stable(req_i) && $stable(en_i) && $stable(prio_i))
      |-> $stable(grant_idx_o));

endmodule

bind prio_rr_arbiter prio_rr_arbiter_chk #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/prio_rr_arbiter_bench.sv
module prio_rr_arbiter_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] en = '0;
  logic [15:0]  prio = '0;
  logic         acc = 1'b0;
  logic         gvld;
  logic [2:0]   gidx;

  typedef struct {
    logic       vld;
    logic [2:0] idx;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  prio_rr_arbiter #(.N_CH(N), .PRIO_W(2)) u_prio_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .prio_i(prio),
    .accept_i(acc), .grant_valid_o(gvld), .grant_idx_o(gidx)
  );

  // Driver: apply one cycle of stimulus and queue what must appear.
  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] e, input logic [15:0] p,
                       input logic a, input logic ev, input logic [2:0] ei, input string tag);
    exp_t item;
    @(negedge clk);
    req = r; en = e; prio = p; acc = a;
    item.vld = ev; item.idx = ei; item.tag = tag;
    exp_q.push_back(item);
  endtask

  // Monitor: compare the queued expectation shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (gvld !== it.vld || (gidx !== it.idx)) begin
          fails++;
          $display("FAIL %s: got vld=%0b idx=%0d, expected vld=%0b idx=%0d",
                   it.tag, gvld, gidx, it.vld, it.idx);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // Reset state, idle (R7)
    drive('0, '0, 16'h0000, 1'b0, 1'b0, 3'd0, "R7 reset idle");
    @(negedge clk); rst_n = 1'b1;
    drive('0, '0, 16'h0000, 1'b0, 1'b0, 3'd0, "R7 idle after reset");
    // R4: lowest pending index first after reset, class 0
    drive(8'h16, 8'hFF, 16'h0000, 1'b0, 1'b1, 3'd1, "R4 first pick after reset");
    // R5: no accept -> same channel again, then accept
    drive(8'h16, 8'hFF, 16'h0000, 1'b1, 1'b1, 3'd1, "R5 repeat without accept");
    drive(8'h16, 8'hFF, 16'h0000, 1'b1, 1'b1, 3'd2, "R4 rotate to 2");
    drive(8'h16, 8'hFF, 16'h0000, 1'b1, 1'b1, 3'd4, "R4 rotate to 4");
    drive(8'h16, 8'hFF, 16'h0000, 1'b1, 1'b1, 3'd1, "R4 wrap to 1");
    // R2 / R1: all requesting but none enabled
    drive(8'hFF, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd1, "R1 R2 masked requests");
    // R2: ch0 requesting but disabled, only ch7 eligible
    drive(8'h81, 8'h80, 16'h0000, 1'b1, 1'b1, 3'd7, "R2 disabled ch0 skipped");
    // R3: ch5 code 0 beats ch3 code 1
    drive(8'h28, 8'hFF, 16'hA26A, 1'b0, 1'b1, 3'd5, "R3 most urgent class");
    // R8: ch5 demoted to 3 -> ch3 now wins
    drive(8'h28, 8'hFF, 16'hAE6A, 1'b0, 1'b1, 3'd3, "R8 priority change");
    // R6: classes 0 (ch2,ch3) and 1 (ch0,ch1)
    drive(8'h0F, 8'hFF, 16'hFF05, 1'b1, 1'b1, 3'd2, "R6 class0 first");
    drive(8'h03, 8'hFF, 16'hFF05, 1'b1, 1'b1, 3'd0, "R6 class1 first");
    drive(8'h0F, 8'hFF, 16'hFF05, 1'b1, 1'b1, 3'd3, "R6 class0 unaffected");
    drive(8'h03, 8'hFF, 16'hFF05, 1'b0, 1'b1, 3'd1, "R6 class1 rotated");
    // R7: idle holds the last index
    drive(8'h00, 8'hFF, 16'hFF05, 1'b0, 1'b0, 3'd1, "R7 hold last index");
    // R5: accept while idle moves nothing
    drive(8'h00, 8'hFF, 16'hFF05, 1'b1, 1'b0, 3'd1, "R5 accept while idle");
    drive(8'h0C, 8'hFF, 16'hFF05, 1'b0, 1'b1, 3'd2, "R5 pointer unmoved");
    drive(8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd2, "R7 hold after pointer check");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule